// File: doc/BRIEF.md
# SPI Four-Mode Serial Clock Shaper

This block turns one internal serial clock, which always idles high and is therefore a Mode 3 clock, into the serial clock for any of the four SPI clock modes. A mask flag gates the internal clock through an AND term to give a low-idle clock. An exclusive-OR stage then inverts that clock whenever the polarity and phase bits differ. Modes 0, 1 and 2 therefore all come from the one Mode 3 source. No separate clock generator exists for each mode.

The mask flag is modelled as a register on the system clock. The internal clock, the active-low select and the active-low read strobe are all sampled on that clock. In a phase-0 mode, a bus read clears the mask while the select is low. Software must therefore do a dummy read before it asserts the slave select. It must also read the received byte after the eighth bit, so that the clock returns to its idle level. In a phase-1 mode the mask is never cleared. A dummy write, which sends the internal clock low once, opens the mask for good.

Top module: `spi_mode_sclk_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it, the mask flag is 0 and `sclkOut` is 0.
- R2: In any system cycle where `intClk` is sampled low and the clear condition is absent, the mask flag is 1 from the next cycle on.
- R3: The clear condition is `selN`=0, `rdN`=0 and `cpha`=0 together. It sets the mask flag to 0 in the next cycle, and it wins over R2 when both apply in the same cycle.
- R4: With `cpha`=1 the mask flag is never cleared, whatever `selN` and `rdN` do.
- R5: `sclkOut` equals (`intClk` AND mask) XOR (`cpol` XOR `cpha`), taken from the values sampled at the previous system clock edge (one cycle of latency).
- R6: With `cpol`=`cpha`=0, once a read has cleared the mask, `sclkOut` stays low through a high `intClk`. It first goes high on the first rising edge of `intClk` after `intClk` has been low.
- R7: With `cpol`≠`cpha` (modes 1 and 2), the output is the inverse of the masked clock. A masked clock therefore idles high at `sclkOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| intClk | input | 1 | Internal Mode 3 serial clock, synchronous to clk |
| selN | input | 1 | Active-low device select |
| rdN | input | 1 | Active-low bus read strobe |
| cpol | input | 1 | Clock polarity bit |
| cpha | input | 1 | Clock phase bit; also the mask-clear enable (0 allows clear) |
| sclkOut | output | 1 | Serial clock for the selected mode |

## Verification
A mask flag stuck at the wrong value shows at `sclkOut` one system cycle after the next high sample of `intClk`. A flag left at 1 when it should be 0 gives a pulse where the idle level belongs. A flag left at 0 swallows the first clock pulse. A wrong priority between set and clear shows up when a read coincides with a low `intClk`: the following high `intClk` then gives the wrong level. A wrong inversion term flips the idle level of modes 1 and 2 in the first cycle after the mode bits change.

// File: rtl/spi_ck_pkg.sv
package spi_ck_pkg;
  typedef struct packed {
    logic maskOn;
    logic invertOut;
  } ckStrobe_t;
endpackage

// File: rtl/spi_ck_ctrl.sv
module spi_ck_ctrl
  import spi_ck_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      intClk,
  input  logic      selN,
  input  logic      rdN,
  input  logic      cpol,
  input  logic      cpha,
  output ckStrobe_t strobe
);
  logic maskQ;
  logic clearReq;
  logic setReq;

  // clear term: select, read and phase-0 all active
  assign clearReq = ~(selN | rdN | cpha);
  assign setReq   = ~intClk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskQ <= 1'b0;
    else if (clearReq) maskQ <= 1'b0;
    else if (setReq) maskQ <= 1'b1;
  end

  always_comb begin
    strobe.maskOn    = maskQ;
    strobe.invertOut = cpol ^ cpha;
  end

  assert_clear_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!selN && !rdN && !cpha) |=> !strobe.maskOn);
  assert_low_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!intClk && (selN || rdN || cpha)) |=> strobe.maskOn);
  assert_phase1_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cpha && strobe.maskOn) |=> strobe.maskOn);
endmodule

// File: rtl/spi_ck_path.sv
module spi_ck_path
  import spi_ck_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      intClk,
  input  ckStrobe_t strobe,
  output logic      sclkOut
);
  logic lowIdle;
  logic shaped;
  logic sclkQ;

  assign lowIdle = intClk & strobe.maskOn;
  assign shaped  = lowIdle ^ strobe.invertOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclkQ <= 1'b0;
    else sclkQ <= shaped;
  end

  assign sclkOut = sclkQ;

  assert_masked_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.maskOn && !strobe.invertOut) |=> !sclkOut);
  assert_masked_inverted_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.maskOn && strobe.invertOut) |=> sclkOut);
  assert_open_follows_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.maskOn && !strobe.invertOut) |=> (sclkOut == $past(intClk)));
endmodule

// File: rtl/spi_mode_sclk_gen.sv
module spi_mode_sclk_gen
  import spi_ck_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic intClk,
  input  logic selN,
  input  logic rdN,
  input  logic cpol,
  input  logic cpha,
  output logic sclkOut
);
  ckStrobe_t strobe;

  spi_ck_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .intClk(intClk), .selN(selN),
    .rdN(rdN), .cpol(cpol), .cpha(cpha), .strobe(strobe)
  );

  spi_ck_path u_path (
    .clk(clk), .rstN(rstN), .intClk(intClk), .strobe(strobe),
    .sclkOut(sclkOut)
  );

  assert_reset_low_R1: assert property (@(posedge clk)
    !rstN |=> (!sclkOut && !strobe.maskOn));
endmodule

// File: tb/spi_mode_sclk_gen_bench.sv
`timescale 1ns/1ps
module spi_mode_sclk_gen_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic intClk = 1'b1, selN = 1'b1, rdN = 1'b1, cpol = 1'b0, cpha = 1'b0;
  logic sclkOut;

  int compared = 0;
  int mismatched = 0;
  int mMask = 0;
  int mOut = 0;
  string curTag = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  spi_mode_sclk_gen u_spi_mode_sclk_gen (
    .clk(clk), .rstN(rstN), .intClk(intClk), .selN(selN),
    .rdN(rdN), .cpol(cpol), .cpha(cpha), .sclkOut(sclkOut)
  );

  // behavioural reference, evaluated at each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      mMask = 0;
      mOut = 0;
    end else begin
      mOut = (int'(intClk) & mMask) ^ (int'(cpol) ^ int'(cpha));
      if (selN == 0 && rdN == 0 && cpha == 0) mMask = 0;
      else if (intClk == 0) mMask = 1;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (int'(sclkOut) != mOut) begin
        mismatched++;
        $display("FAIL %s at %0t: sclkOut=%0d expected=%0d", curTag, $time, sclkOut, mOut);
      end
    end
  end

  task automatic step(input logic ic, input logic s, input logic r);
    @(negedge clk); #1;
    intClk = ic; selN = s; rdN = r;
  endtask

  task automatic shiftByte();
    for (int b = 0; b < 8; b++) begin
      step(1'b0, 1'b0, 1'b1); step(1'b0, 1'b0, 1'b1);
      step(1'b1, 1'b0, 1'b1); step(1'b1, 1'b0, 1'b1);
    end
  endtask

  task automatic runMode(input logic p, input logic h);
    @(negedge clk); #1;
    cpol = p; cpha = h;
    curTag = (p != h) ? "R7" : "R5";
    step(1'b1, 1'b1, 1'b1); step(1'b1, 1'b1, 1'b1);
    if (h == 1'b0) begin
      curTag = "R6";                          // dummy read, then select
      step(1'b1, 1'b0, 1'b0); step(1'b1, 1'b1, 1'b1);
      step(1'b1, 1'b0, 1'b1); step(1'b1, 1'b0, 1'b1);
    end else begin
      curTag = "R4";                          // dummy write, reads ignored
      step(1'b0, 1'b1, 1'b1); step(1'b1, 1'b1, 1'b1);
      step(1'b1, 1'b0, 1'b0); step(1'b1, 1'b0, 1'b0);
    end
    curTag = (p != h) ? "R7" : "R5";
    shiftByte();
    curTag = (h == 1'b0) ? "R6" : "R4";     // closing read of the byte
    step(1'b1, 1'b0, 1'b0); step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1); step(1'b1, 1'b1, 1'b1);
  endtask

  initial begin
    curTag = "R1";
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    step(1'b1, 1'b1, 1'b1); step(1'b1, 1'b1, 1'b1);

    runMode(1'b0, 1'b0);
    runMode(1'b0, 1'b1);
    runMode(1'b1, 1'b0);
    runMode(1'b1, 1'b1);

    // set and clear in the same cycle: clear must win
    @(negedge clk); #1; cpol = 1'b0; cpha = 1'b0;
    curTag = "R2";
    step(1'b0, 1'b1, 1'b1);
    curTag = "R3";
    step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1); step(1'b1, 1'b1, 1'b1); step(1'b1, 1'b1, 1'b1);

    // free stimulus across all modes
    curTag = "R5";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      intClk = 1'($urandom); selN = 1'($urandom); rdN = 1'($urandom);
      if (($urandom % 16) == 0) begin cpol = 1'($urandom); cpha = 1'($urandom); end
    end

    // reset in mid-run
    curTag = "R1";
    @(negedge clk); #1; rstN = 1'b0; intClk = 1'b1; cpol = 1'b0; cpha = 1'b0;
    @(negedge clk); #1; rstN = 1'b1;
    step(1'b1, 1'b1, 1'b1); step(1'b1, 1'b1, 1'b1);

    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not end, actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule